// File: doc/BRIEF.md
# Self-Repairing Counting Bloom Filter

This block answers set-membership questions for fixed-width keys with a counting Bloom filter. The counter array (fast storage) and the set of stored keys (a slot-addressed element store) are both kept inside the block, and every word of each carries one even-parity bit. A caller inserts a key into a chosen element slot, removes the key held in a slot, or asks whether a key may be a member. Each accepted command gets exactly one response code on the following cycle.

Because the element store and the counters describe the same set twice, each can repair the other. A corrupted counter word makes the block wipe the whole counter array and rebuild it by walking the element store. A corrupted element word makes the block try every single-bit correction of that word and keep the one the counters vouch for. If no single candidate qualifies, the slot is emptied and the counters are rebuilt. A background scrubber reads one counter word and one element word on every idle cycle, so that upsets are found before a command touches them. A fault-injection input flips one stored bit so that the repair paths can be exercised.

Top module: `cbf_selfrepair`

## Requirements
- R1: A query (cmd_op 0) answers HIT (code 1) when all K counters selected by the key are nonzero, otherwise MISS (code 2). Hash h (0 to K-1) rotates the key left by 5*h mod W bits, then XORs bit j of the rotated word into index bit j mod log2(NC).
- R2: An insert (cmd_op 1) into an empty slot stores the key, adds one to the counter at every hashed index (an index hit by two hash functions gets two), and answers OK (code 0). An insert into an occupied slot answers REJECT (code 3) and changes nothing.
- R3: A remove (cmd_op 2) of an occupied slot empties it (writes an all-zero word), subtracts one per hashed index of the stored key, and answers OK. A remove of an empty slot answers REJECT and changes nothing.
- R4: A counter stays at its maximum (15 by default) when incremented and stays at zero when decremented.
- R5: Words use even parity. Element word bits are [W+1] parity, [W] valid, [W-1:0] key; counter word bits are [CW] parity, [CW-1:0] count. A command whose counter or slot read fails parity answers BUSY (code 4), is not performed, and starts a repair.
- R6: With no commands, the scrubber finds a single flipped bit in any counter word and the repair finishes within NC+NE+4 cycles of the flip.
- R7: A counter parity error clears the counter array and rebuilds it from the valid slots, one slot per cycle; membership answers afterwards match the stored set.
- R8: An element parity error tries W+2 candidates (each of the W+1 data bits flipped, then the data unchanged). A candidate qualifies if its valid bit is set and all its K counters are nonzero, or if it is all zero. With exactly one qualifier it is written back and repair_done pulses with repair_fail low.
- R9: With zero or several qualifiers the slot is emptied, the counters are rebuilt, and repair_done pulses with repair_fail high.
- R10: While a repair runs, busy is high and every command answers BUSY with no effect; repair_done pulses for one cycle as busy falls.
- R11: rsp_valid is high exactly on the cycle after each cmd_valid cycle; cmd_op 3 answers REJECT. After reset the filter is empty and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 query, 1 insert, 2 remove, 3 reserved |
| cmd_key | input | W | Key for query and insert |
| cmd_slot | input | log2(NE) | Element slot for insert and remove |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | 0 OK, 1 HIT, 2 MISS, 3 REJECT, 4 BUSY |
| busy | output | 1 | Repair in progress |
| repair_done | output | 1 | One-cycle pulse at end of repair |
| repair_fail | output | 1 | With repair_done: element correction failed |
| inj_en | input | 1 | Flip one stored bit this cycle |
| inj_mem | input | 1 | 0 counter array, 1 element store |
| inj_addr | input | log2(NC) | Counter index, or slot in low bits |
| inj_bit | input | log2(W+2) | Bit to flip inside the word |

## Verification
The hardest situation to reach is an element-word upset whose candidate count is exactly one versus several, because that depends on how the other stored keys happen to populate the counters. The stimulus flips every bit position, parity and valid bit included, of both an occupied slot and an empty slot. The bench keeps its own counter model to predict, for each flip, whether the correction succeeds or the slot is dropped. Errors are injected both while idle, so that the scrubber finds them, and right before a command that reads the damaged word, so that the command itself finds them.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
    typedef enum logic [1:0] {
        OP_QUERY  = 2'd0,
        OP_INSERT = 2'd1,
        OP_REMOVE = 2'd2,
        OP_RSVD   = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        RSP_OK     = 3'd0,
        RSP_HIT    = 3'd1,
        RSP_MISS   = 3'd2,
        RSP_REJECT = 3'd3,
        RSP_BUSY   = 3'd4
    } rsp_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_REBUILD,
        ST_FIX
    } state_t;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_INC,
        UPD_DEC
    } upd_t;

    // rotation step between successive hash functions
    localparam int HASH_STRIDE = 5;
endpackage

// File: rtl/cbf_hash.sv
module cbf_hash
    import cbf_pkg::*;
#(
    parameter int W  = 16,
    parameter int K  = 3,
    parameter int IW = 6
) (
    input  logic [W-1:0]          key,
    output logic [K-1:0][IW-1:0]  idx
);
    logic [2*W-1:0] dbl;
    assign dbl = {key, key};

    for (genvar h = 0; h < K; h++) begin : g_fn
        localparam int R = (HASH_STRIDE * h) % W;
        logic [W-1:0]  rot;
        logic [IW-1:0] fold;
        assign rot = dbl[2*W-1-R -: W];
        always_comb begin
            fold = '0;
            for (int j = 0; j < W; j++) fold[j % IW] = fold[j % IW] ^ rot[j];
        end
        assign idx[h] = fold;
    end
endmodule

// File: rtl/cbf_ctr_array.sv
module cbf_ctr_array
    import cbf_pkg::*;
#(
    parameter int NC  = 64,
    parameter int CW  = 4,
    parameter int K   = 3,
    localparam int IW  = $clog2(NC),
    localparam int CBW = $clog2(CW+1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  upd_t                  upd,
    input  logic [K-1:0][IW-1:0]  idx_a,
    input  logic [K-1:0][IW-1:0]  idx_b,
    input  logic [IW-1:0]         scrub_idx,
    input  logic                  inj_en,
    input  logic [IW-1:0]         inj_idx,
    input  logic [CBW-1:0]        inj_bit,
    output logic [K-1:0][CW-1:0]  val_a,
    output logic [K-1:0]          pok_a,
    output logic [K-1:0][CW-1:0]  val_b,
    output logic                  scrub_ok
);
    localparam int CMAX = (1 << CW) - 1;

    logic [CW:0] mem [NC];
    logic [CW:0] nxt [NC];
    int          hits;
    int          cur;
    int          res;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            hits = 0;
            for (int k = 0; k < K; k++) hits = hits + ((idx_a[k] == IW'(i)) ? 1 : 0);
            cur = int'(mem[i][CW-1:0]);
            res = cur;
            if (upd == UPD_INC) res = (cur + hits > CMAX) ? CMAX : cur + hits;
            else if (upd == UPD_DEC) res = (hits > cur) ? 0 : cur - hits;
            if (clr) nxt[i] = '0;
            else if (upd != UPD_NONE && hits != 0)
                nxt[i] = {^CW'(res), CW'(res)};
            else nxt[i] = mem[i];
            if (inj_en && inj_idx == IW'(i)) nxt[i][inj_bit] = ~nxt[i][inj_bit];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NC; i++) mem[i] <= rst ? '0 : nxt[i];
    end

    always_comb begin
        for (int k = 0; k < K; k++) begin
            val_a[k] = mem[idx_a[k]][CW-1:0];
            pok_a[k] = ~^mem[idx_a[k]];
            val_b[k] = mem[idx_b[k]][CW-1:0];
        end
        scrub_ok = ~^mem[scrub_idx];
    end

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr && !inj_en |=> val_a == '0); // R7

    for (genvar g = 0; g < NC; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            upd == UPD_INC && !clr && !inj_en && mem[g][CW-1:0] == CW'(CMAX)
            |=> mem[g][CW-1:0] == CW'(CMAX)); // R4
        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
            upd == UPD_DEC && !clr && !inj_en && mem[g][CW-1:0] == '0
            |=> mem[g][CW-1:0] == '0); // R4
    end
endmodule

// File: rtl/cbf_selfrepair.sv
module cbf_selfrepair
    import cbf_pkg::*;
#(
    parameter int W  = 16,
    parameter int NE = 16,
    parameter int NC = 64,
    parameter int CW = 4,
    parameter int K  = 3,
    localparam int SW  = $clog2(NE),
    localparam int IW  = $clog2(NC),
    localparam int BW  = $clog2(W+2),
    localparam int CBW = $clog2(CW+1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [W-1:0]   cmd_key,
    input  logic [SW-1:0]  cmd_slot,
    output logic           rsp_valid,
    output logic [2:0]     rsp_code,
    output logic           busy,
    output logic           repair_done,
    output logic           repair_fail,
    input  logic           inj_en,
    input  logic           inj_mem,
    input  logic [IW-1:0]  inj_addr,
    input  logic [BW-1:0]  inj_bit
);
    state_t       state;
    logic [W+1:0] emem [NE];
    logic [IW-1:0] sptr;
    logic [SW-1:0] rb_ptr, fix_slot;
    logic [BW-1:0] cand;
    logic [1:0]    qcnt, qsum;
    logic [W:0]    fix_data, first_hit, cand_data, cand_mask, fix_word;
    logic          fail_pend;

    op_t                 op;
    logic [W+1:0]        slot_word, rb_word, scrub_word;
    logic [W-1:0]        key_a;
    logic [K-1:0][IW-1:0] idx_a, idx_b;
    logic [K-1:0][CW-1:0] val_a, val_b;
    logic [K-1:0]        pok_a;
    logic                scrub_ok, all_nz_a, all_nz_b, cand_q;
    logic                go, err_ctr, err_slot, do_ins, do_rem;
    upd_t                upd;

    assign op   = op_t'(cmd_op);
    assign busy = (state != ST_IDLE);

    always_comb begin
        slot_word  = emem[cmd_slot];
        rb_word    = emem[rb_ptr];
        scrub_word = emem[sptr[SW-1:0]];
        if (state == ST_REBUILD)    key_a = rb_word[W-1:0];
        else if (op == OP_REMOVE)   key_a = slot_word[W-1:0];
        else                        key_a = cmd_key;
        cand_mask = '0;
        if (cand <= BW'(W)) cand_mask[cand] = 1'b1;
        cand_data = fix_data ^ cand_mask;
        all_nz_a = 1'b1;
        all_nz_b = 1'b1;
        for (int k = 0; k < K; k++) begin
            if (val_a[k] == '0) all_nz_a = 1'b0;
            if (val_b[k] == '0) all_nz_b = 1'b0;
        end
        cand_q   = cand_data[W] ? all_nz_b : (cand_data[W-1:0] == '0);
        qsum     = qcnt + 2'(cand_q);
        fix_word = (qcnt == 2'd0) ? cand_data : first_hit;

        go       = (state == ST_IDLE) && cmd_valid;
        err_ctr  = go && op != OP_RSVD && !(&pok_a);
        err_slot = go && (op == OP_INSERT || op == OP_REMOVE) && !err_ctr && (^slot_word);
        do_ins   = go && op == OP_INSERT && !err_ctr && !err_slot && !slot_word[W];
        do_rem   = go && op == OP_REMOVE && !err_ctr && !err_slot && slot_word[W];

        if (do_ins || (state == ST_REBUILD && rb_word[W])) upd = UPD_INC;
        else if (do_rem)                                   upd = UPD_DEC;
        else                                               upd = UPD_NONE;
    end

    cbf_hash #(.W(W), .K(K), .IW(IW)) u_hash_a (.key(key_a), .idx(idx_a));
    cbf_hash #(.W(W), .K(K), .IW(IW)) u_hash_b (.key(cand_data[W-1:0]), .idx(idx_b));

    cbf_ctr_array #(.NC(NC), .CW(CW), .K(K)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .clr       (state == ST_CLEAR),
        .upd       (upd),
        .idx_a     (idx_a),
        .idx_b     (idx_b),
        .scrub_idx (sptr),
        .inj_en    (inj_en && !inj_mem),
        .inj_idx   (inj_addr),
        .inj_bit   (inj_bit[CBW-1:0]),
        .val_a     (val_a),
        .pok_a     (pok_a),
        .val_b     (val_b),
        .scrub_ok  (scrub_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_code    <= RSP_OK;
            repair_done <= 1'b0;
            repair_fail <= 1'b0;
            sptr        <= '0;
            rb_ptr      <= '0;
            fix_slot    <= '0;
            cand        <= '0;
            qcnt        <= '0;
            fix_data    <= '0;
            first_hit   <= '0;
            fail_pend   <= 1'b0;
            for (int s = 0; s < NE; s++) emem[s] <= '0;
        end else begin
            rsp_valid   <= cmd_valid;
            rsp_code    <= RSP_BUSY;
            repair_done <= 1'b0;
            repair_fail <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (err_ctr) begin
                            state     <= ST_CLEAR;
                            fail_pend <= 1'b0;
                        end else if (err_slot) begin
                            state    <= ST_FIX;
                            fix_slot <= cmd_slot;
                            fix_data <= slot_word[W:0];
                            cand     <= '0;
                            qcnt     <= '0;
                        end else begin
                            case (op)
                                OP_QUERY:  rsp_code <= all_nz_a ? RSP_HIT : RSP_MISS;
                                OP_INSERT: rsp_code <= do_ins ? RSP_OK : RSP_REJECT;
                                OP_REMOVE: rsp_code <= do_rem ? RSP_OK : RSP_REJECT;
                                default:   rsp_code <= RSP_REJECT;
                            endcase
                            if (do_ins) emem[cmd_slot] <= {^{1'b1, cmd_key}, 1'b1, cmd_key};
                            if (do_rem) emem[cmd_slot] <= '0;
                        end
                    end else begin
                        if (!scrub_ok) begin
                            state     <= ST_CLEAR;
                            fail_pend <= 1'b0;
                        end else if (^scrub_word) begin
                            state    <= ST_FIX;
                            fix_slot <= sptr[SW-1:0];
                            fix_data <= scrub_word[W:0];
                            cand     <= '0;
                            qcnt     <= '0;
                        end
                        sptr <= sptr + 1'b1;
                    end
                end
                ST_CLEAR: begin
                    state  <= ST_REBUILD;
                    rb_ptr <= '0;
                end
                ST_REBUILD: begin
                    rb_ptr <= rb_ptr + 1'b1;
                    if (rb_ptr == SW'(NE-1)) begin
                        state       <= ST_IDLE;
                        repair_done <= 1'b1;
                        repair_fail <= fail_pend;
                    end
                end
                ST_FIX: begin
                    if (cand_q && qcnt == 2'd0) first_hit <= cand_data;
                    if (cand_q && qcnt != 2'd2) qcnt <= qcnt + 1'b1;
                    cand <= cand + 1'b1;
                    if (cand == BW'(W+1)) begin
                        if (qsum == 2'd1) begin
                            emem[fix_slot] <= {^fix_word, fix_word};
                            state          <= ST_IDLE;
                            repair_done    <= 1'b1;
                        end else begin
                            emem[fix_slot] <= '0;
                            fail_pend      <= 1'b1;
                            state          <= ST_CLEAR;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (inj_en && inj_mem)
                emem[inj_addr[SW-1:0]][inj_bit] <= ~emem[inj_addr[SW-1:0]][inj_bit];
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid); // R11
    AST_RSP_ONLY: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid); // R11
    AST_BUSY_REPLY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && busy |=> rsp_code == RSP_BUSY); // R10
    AST_ERR_BUSY: assert property (@(posedge clk) disable iff (rst)
        err_ctr || err_slot |=> busy && rsp_code == RSP_BUSY); // R5
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        repair_done |-> !busy && $past(busy)); // R10
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        repair_fail |-> repair_done); // R9
endmodule

// File: tb/tb_cbf_selfrepair.sv
`timescale 1ns/1ps
module tb_cbf_selfrepair;
    localparam int W = 16, NE = 16, NC = 64, CW = 4, K = 3;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] cmd_key = '0;
    logic [3:0]  cmd_slot = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic        busy, repair_done, repair_fail;
    logic        inj_en = 1'b0;
    logic        inj_mem = 1'b0;
    logic [5:0]  inj_addr = '0;
    logic [4:0]  inj_bit = '0;

    always #2 clk = ~clk;

    cbf_selfrepair dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_key(cmd_key), .cmd_slot(cmd_slot), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .busy(busy), .repair_done(repair_done),
        .repair_fail(repair_fail), .inj_en(inj_en), .inj_mem(inj_mem),
        .inj_addr(inj_addr), .inj_bit(inj_bit)
    );

    int n_chk = 0, n_fail = 0;
    int mc [NC];
    bit me_v [NE];
    logic [15:0] me_k [NE];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    // model hash: rotate left by 5*h mod 16, fold bit j into index bit j mod 6
    function automatic int hidx(input logic [15:0] k, input int h);
        logic [31:0] d;
        logic [15:0] rot;
        logic [5:0]  ix;
        int r;
        d = {k, k};
        r = (5 * h) % 16;
        rot = d[31-r -: 16];
        ix = '0;
        for (int j = 0; j < 16; j++) ix[j % 6] = ix[j % 6] ^ rot[j];
        return int'(ix);
    endfunction

    function automatic bit m_query(input logic [15:0] k);
        for (int h = 0; h < K; h++) if (mc[hidx(k, h)] == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void m_ins(input logic [15:0] k);
        for (int h = 0; h < K; h++) if (mc[hidx(k, h)] < CMAX) mc[hidx(k, h)]++;
    endfunction

    function automatic void m_rem(input logic [15:0] k);
        for (int h = 0; h < K; h++) if (mc[hidx(k, h)] > 0) mc[hidx(k, h)]--;
    endfunction

    function automatic void m_rebuild();
        for (int i = 0; i < NC; i++) mc[i] = 0;
        for (int s = 0; s < NE; s++) if (me_v[s]) m_ins(me_k[s]);
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < NC; i++) mc[i] = 0;
        for (int s = 0; s < NE; s++) begin me_v[s] = 0; me_k[s] = '0; end
    endfunction

    // predicted outcome of a single-bit correction after flipping bit b
    function automatic bit fix_ok(input logic [16:0] orig, input int b);
        logic [16:0] d, cd;
        int q;
        d = orig;
        if (b <= 16) d[b] = ~d[b];
        q = 0;
        for (int c = 0; c <= 17; c++) begin
            cd = d;
            if (c <= 16) cd[c] = ~cd[c];
            if (cd[16] ? m_query(cd[15:0]) : (cd[15:0] == 16'h0)) q++;
        end
        return q == 1;
    endfunction

    task automatic send(input logic [1:0] op, input logic [15:0] key, input int slot,
                        output logic [2:0] code);
        cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_slot = 4'(slot);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R11 rsp_valid after command", int'(rsp_valid), 1);
        code = rsp_code;
    endtask

    task automatic do_query(input logic [15:0] key, input string req);
        logic [2:0] c;
        int e;
        send(2'd0, key, 0, c);
        e = m_query(key) ? 1 : 2;
        chk(int'(c) == e, req, int'(c), e);
    endtask

    task automatic do_insert(input logic [15:0] key, input int slot);
        logic [2:0] c;
        int e;
        send(2'd1, key, slot, c);
        e = me_v[slot] ? 3 : 0;
        chk(int'(c) == e, "R2 insert code", int'(c), e);
        if (!me_v[slot]) begin me_v[slot] = 1; me_k[slot] = key; m_ins(key); end
    endtask

    task automatic do_remove(input int slot);
        logic [2:0] c;
        int e;
        send(2'd2, 16'h0, slot, c);
        e = me_v[slot] ? 0 : 3;
        chk(int'(c) == e, "R3 remove code", int'(c), e);
        if (me_v[slot]) begin me_v[slot] = 0; m_rem(me_k[slot]); me_k[slot] = '0; end
    endtask

    task automatic inject(input bit mem, input int addr, input int b);
        inj_en = 1'b1; inj_mem = mem; inj_addr = 6'(addr); inj_bit = 5'(b);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic wait_done(output bit f, output int cyc);
        bit seen;
        seen = 0; f = 0; cyc = 0;
        for (int i = 1; i <= 400 && !seen; i++) begin
            @(negedge clk);
            if (repair_done) begin seen = 1; f = repair_fail; cyc = i; end
        end
        chk(seen, "R10 repair_done seen", int'(seen), 1);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 96; i++) do_query(16'(i * 16'h01F3) ^ 16'h005A, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_clear();
    endtask

    task automatic elem_sweep(input int slot, input logic [15:0] key, input bit occupy);
        bit f, e;
        int cyc;
        logic [16:0] orig;
        for (int b = 0; b <= 17; b++) begin
            if (occupy && !me_v[slot]) do_insert(key, slot);
            orig = me_v[slot] ? {1'b1, me_k[slot]} : 17'h0;
            e = fix_ok(orig, b);
            inject(1'b1, slot, b);
            wait_done(f, cyc);
            chk(f == !e, e ? "R8 correction accepted" : "R9 correction refused",
                int'(f), int'(!e));
            if (!e) begin me_v[slot] = 0; me_k[slot] = '0; m_rebuild(); end
            do_query(key, "R8 membership after element repair");
        end
    endtask

    initial begin : main
        logic [2:0] c;
        bit f, e;
        int cyc;
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0, "R11 busy after reset", int'(busy), 0);
        chk(rsp_valid === 1'b0, "R11 rsp_valid after reset", int'(rsp_valid), 0);
        chk(repair_done === 1'b0, "R11 repair_done after reset", int'(repair_done), 0);
        do_query(16'hA5C3, "R1 empty filter misses");

        // build a set
        do_insert(16'hA5C3, 0);
        do_insert(16'hBEEF, 1);
        do_insert(16'h3C1E, 3);
        do_insert(16'h0F0F, 5);
        do_insert(16'h7777, 6);
        do_insert(16'h1248, 7);
        sweep("R1 query sweep");
        do_insert(16'h4321, 0);
        do_query(16'h4321, "R2 rejected insert leaves counters");
        do_remove(2);
        do_remove(6);
        do_query(16'h7777, "R3 removed key");
        sweep("R3 query sweep after remove");
        send(2'd3, 16'h0, 0, c);
        chk(c == 3'd3, "R11 reserved op rejected", int'(c), 3);

        // counter upset found by the scrubber
        inject(1'b0, 40, 4);
        wait_done(f, cyc);
        chk(f == 0, "R7 rebuild without fail", int'(f), 0);
        chk(cyc <= NC + NE + 4, "R6 scrub latency", cyc, NC + NE + 4);
        m_rebuild();
        sweep("R7 query sweep after rebuild");

        // counter upset found by a command, commands during repair
        inject(1'b0, hidx(16'hBEEF, 0), 1);
        send(2'd0, 16'hBEEF, 0, c);
        chk(c == 3'd4, "R5 counter parity on query gives BUSY", int'(c), 4);
        chk(busy === 1'b1, "R10 busy during repair", int'(busy), 1);
        send(2'd1, 16'h2222, 9, c);
        chk(c == 3'd4, "R10 insert during repair gives BUSY", int'(c), 4);
        wait_done(f, cyc);
        chk(f == 0, "R7 rebuild flag", int'(f), 0);
        m_rebuild();
        do_query(16'h2222, "R10 insert during repair had no effect");
        do_insert(16'h2222, 9);
        sweep("R7 sweep after command-detected rebuild");

        // element upset found by a remove
        e = fix_ok({1'b1, me_k[3]}, 5);
        inject(1'b1, 3, 5);
        send(2'd2, 16'h0, 3, c);
        chk(c == 3'd4, "R5 element parity on remove gives BUSY", int'(c), 4);
        wait_done(f, cyc);
        chk(f == !e, "R8 remove-detected correction", int'(f), int'(!e));
        if (!e) begin me_v[3] = 0; me_k[3] = '0; m_rebuild(); end
        do_insert(16'h5555, 3);

        // every bit of an occupied and an empty slot
        elem_sweep(0, 16'hA5C3, 1'b1);
        elem_sweep(12, 16'h0000, 1'b0);
        sweep("R8 sweep after element repairs");

        // saturation and floor
        do_reset();
        for (int s = 0; s < NE; s++) do_insert(16'h1234, s);
        do_query(16'h1234, "R4 saturated key hits");
        for (int s = 0; s < NE - 1; s++) do_remove(s);
        do_query(16'h1234, "R4 counter saturated at max");
        do_remove(NE - 1);
        do_query(16'h1234, "R4 counter floors at zero");
        do_insert(16'h1234, 0);
        do_query(16'h1234, "R4 count after floor");

        finish_up();
    end
endmodule